// File: doc/BRIEF.md
# Slave Clock Ratio Monitor

This block watches the three clocks an audio converter receives when it runs as a clock slave. All of its logic runs on the master clock. It brings the frame clock and the bit clock into that domain. It counts master clock cycles from one frame clock rising edge to the next and maps the count to one of six supported ratios: 128, 192, 256, 384, 512 or 768 times the sample rate. It then says whether that ratio is allowed for the current oversampling selection.

The oversampling selection comes from a three-level pin, which a pad decoder outside this block resolves into two bits. A low pin covers sample rates up to 48 kHz and allows ratios 256 to 768. A high pin covers 88.2 and 96 kHz and allows 128 to 384. A floating pin covers 176.4 and 192 kHz and allows only 128 and 192.

The block also reports a lock once the same ratio has been measured for several frames in a row. It raises a flag when the bit clock toggles faster than the master clock can resolve. Other logic uses these outputs to hold off or flag conversion while the clocks are wrong.

Top module: `clk_ratio_mon`

## Requirements
- R1: During and after reset, with no measurement made yet, `ratio_code_o` is 7, and `ratio_ok_o`, `locked_o` and `bclk_fast_o` are 0.
- R2: A measurement is the number of master clock cycles between two successive frame clock rising edges. The first rising edge after reset, or after a timeout, only starts the count and produces no measurement. A measurement shows on `ratio_code_o` within six master clock cycles of the rising edge that closes it.
- R3: The ratio code is 0, 1, 2, 3, 4 or 5 for a count within ±2 of 128, 192, 256, 384, 512 or 768 respectively. Any other count gives code 7.
- R4: With `osr_sel_i` = 2'b00 (low), `ratio_ok_o` is 1 exactly when the code is 2, 3, 4 or 5.
- R5: With `osr_sel_i` = 2'b01 (high), `ratio_ok_o` is 1 exactly when the code is 0, 1, 2 or 3.
- R6: With `osr_sel_i` = 2'b10 (floating), `ratio_ok_o` is 1 exactly when the code is 0 or 1. With 2'b11 (reserved), `ratio_ok_o` is always 0.
- R7: `ratio_ok_o` follows a change of `osr_sel_i` one master clock cycle later, without waiting for a new measurement, and is 0 whenever the code is 7.
- R8: `locked_o` rises when three consecutive measurements give the same code other than 7. It falls on the first measurement that gives a different code or code 7.
- R9: If no frame clock rising edge arrives for 1023 master clock cycles, a measurement of code 7 is reported and `locked_o` falls.
- R10: `bclk_fast_o` is set when the synchronized bit clock changes level in two consecutive master clock cycles. It stays set until a frame clock rising edge closes a frame in which no such event occurred.
- R11: A bit clock whose level holds for at least two master clock cycles never sets `bclk_fast_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Bit clock, asynchronous to `clk` |
| lrclk_i | input | 1 | Frame clock, asynchronous to `clk` |
| osr_sel_i | input | 2 | Decoded oversampling pin: 00 low, 01 high, 10 floating, 11 reserved |
| ratio_code_o | output | 3 | Last measured ratio code (0..5, or 7 if unrecognized) |
| ratio_ok_o | output | 1 | Ratio is legal for the current oversampling selection |
| bclk_fast_o | output | 1 | Bit clock toggles faster than the master clock can resolve |
| locked_o | output | 1 | Same valid ratio measured for three consecutive frames |

## Verification
The bench walks every nominal ratio under each oversampling level. A legality table with a wrong entry would show as `ratio_ok_o` asserting for a forbidden ratio such as 768 in the high setting or 384 in the floating one. It probes counts of 125, 126, 130 and 131 around the 128 nominal. An off-by-one in the tolerance window or in the cycle counter would move one of those across the accept boundary. It switches ratio while locked and stops the frame clock outright, so a lock that fails to fall on the first differing frame, or a counter that never times out, holds a stale lock. It drives the bit clock at one and two master cycles per level. A monitor that compared the wrong edges would flag the legal slow clock or miss the fast one.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

  localparam int NUM_RATIOS = 6;
  localparam logic [2:0] CODE_NONE = 3'd7;

  typedef enum logic [1:0] {
    OSR_LOW   = 2'b00,
    OSR_HIGH  = 2'b01,
    OSR_FLOAT = 2'b10,
    OSR_RSVD  = 2'b11
  } osr_sel_e;

  // nominal ratio for code idx: 64 * {2,3,4,6,8,12}
  function automatic int unsigned nominal_ratio(input int unsigned idx);
    int unsigned mult;
    mult = (idx % 2 == 0) ? (2 << (idx / 2)) : (3 << (idx / 2));
    return 64 * mult;
  endfunction

  function automatic logic code_legal(input logic [2:0] code, input logic [1:0] osr);
    logic ok;
    ok = 1'b0;
    if (code != CODE_NONE) begin
      case (osr)
        OSR_LOW:   ok = (code >= 3'd2) && (code <= 3'd5);
        OSR_HIGH:  ok = (code <= 3'd3);
        OSR_FLOAT: ok = (code <= 3'd1);
        default:   ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/crm_sync.sv
module crm_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/crm_period_meter.sv
module crm_period_meter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_i,
  output logic             frame_tick_o,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             lvl_q;
  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise         = lvl_i & ~lvl_q;
  assign frame_tick_o = rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q      <= 1'b0;
      seen_q     <= 1'b0;
      cnt_q      <= '0;
      meas_vld_o <= 1'b0;
      meas_o     <= '0;
    end else begin
      lvl_q      <= lvl_i;
      meas_vld_o <= 1'b0;
      if (rise) begin
        if (seen_q) begin
          meas_vld_o <= 1'b1;
          meas_o     <= cnt_q;
        end
        seen_q <= 1'b1;
        cnt_q  <= CNT_ONE;
      end else if (cnt_q == CNT_MAX) begin
        // frame clock absent: report an out-of-range period and restart
        meas_vld_o <= 1'b1;
        meas_o     <= CNT_MAX;
        seen_q     <= 1'b0;
        cnt_q      <= CNT_ONE;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/crm_ratio_classify.sv
module crm_ratio_classify
  import clk_ratio_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meas_vld_i,
  input  logic [CNT_W-1:0] meas_i,
  output logic             vld_o,
  output logic [2:0]       code_o
);

  logic [31:0]           meas_w;
  logic [NUM_RATIOS-1:0] hit;
  logic [2:0]            code_c;

  assign meas_w = 32'(meas_i);

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
    localparam logic [31:0] LO = 32'(nominal_ratio(i) - TOL);
    localparam logic [31:0] HI = 32'(nominal_ratio(i) + TOL);
    assign hit[i] = (meas_w >= LO) && (meas_w <= HI);
  end

  always_comb begin
    code_c = CODE_NONE;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit[i]) code_c = 3'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      code_o <= CODE_NONE;
    end else begin
      vld_o <= meas_vld_i;
      if (meas_vld_i) code_o <= code_c;
    end
  end

endmodule

// File: rtl/crm_bclk_monitor.sv
module crm_bclk_monitor (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic frame_tick_i,
  output logic too_fast_o
);

  logic lvl_q;
  logic chg_q;
  logic acc_q;
  logic chg;
  logic viol;

  assign chg  = lvl_i ^ lvl_q;
  assign viol = chg & chg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q      <= 1'b0;
      chg_q      <= 1'b0;
      acc_q      <= 1'b0;
      too_fast_o <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      chg_q <= chg;
      acc_q <= frame_tick_i ? 1'b0 : (acc_q | viol);
      if (viol)              too_fast_o <= 1'b1;
      else if (frame_tick_i) too_fast_o <= acc_q;
    end
  end

endmodule

// File: rtl/clk_ratio_mon.sv
module clk_ratio_mon
  import clk_ratio_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int TOL         = 2,
  parameter int LOCK_FRAMES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bclk_i,
  input  logic       lrclk_i,
  input  logic [1:0] osr_sel_i,
  output logic [2:0] ratio_code_o,
  output logic       ratio_ok_o,
  output logic       bclk_fast_o,
  output logic       locked_o
);

  localparam int RUN_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_FRAMES);

  logic [1:0]       sync_q;
  logic             frame_tick;
  logic             meas_vld;
  logic [CNT_W-1:0] meas;
  logic             cls_vld;
  logic [2:0]       cls_code;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nxt;
  logic [2:0]       code_nxt;

  crm_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({bclk_i, lrclk_i}),
    .q_o (sync_q)
  );

  crm_period_meter #(.CNT_W(CNT_W)) i_meter (
    .clk          (clk),
    .rst          (rst),
    .lvl_i        (sync_q[0]),
    .frame_tick_o (frame_tick),
    .meas_vld_o   (meas_vld),
    .meas_o       (meas)
  );

  crm_ratio_classify #(.CNT_W(CNT_W), .TOL(TOL)) i_classify (
    .clk        (clk),
    .rst        (rst),
    .meas_vld_i (meas_vld),
    .meas_i     (meas),
    .vld_o      (cls_vld),
    .code_o     (cls_code)
  );

  crm_bclk_monitor i_bmon (
    .clk          (clk),
    .rst          (rst),
    .lvl_i        (sync_q[1]),
    .frame_tick_i (frame_tick),
    .too_fast_o   (bclk_fast_o)
  );

  // consecutive-frame run length, saturating at the lock threshold
  always_comb begin
    run_nxt = run_q;
    if (cls_vld) begin
      if (cls_code == CODE_NONE)         run_nxt = '0;
      else if (cls_code == ratio_code_o) run_nxt = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
      else                               run_nxt = RUN_W'(1);
    end
  end

  assign code_nxt = cls_vld ? cls_code : ratio_code_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q        <= '0;
      ratio_code_o <= CODE_NONE;
      ratio_ok_o   <= 1'b0;
      locked_o     <= 1'b0;
    end else begin
      run_q        <= run_nxt;
      ratio_code_o <= code_nxt;
      ratio_ok_o   <= code_legal(code_nxt, osr_sel_i);
      locked_o     <= (run_nxt >= RUN_MAX);
    end
  end

endmodule

// File: rtl/clk_ratio_mon_chk.sv
module clk_ratio_mon_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] osr_sel_i,
  input logic [2:0] ratio_code_o,
  input logic       ratio_ok_o,
  input logic       locked_o
);

  // R3: only codes 0..5 or 7 appear
  p_code_range_r3: assert property (@(posedge clk) disable iff (rst)
    (ratio_code_o <= 3'd5) || (ratio_code_o == 3'd7));

  // R7: no legal flag for an unrecognized ratio
  p_ok_code_r7: assert property (@(posedge clk) disable iff (rst)
    ratio_ok_o |-> (ratio_code_o != 3'd7));

  // R4
  p_ok_low_r4: assert property (@(posedge clk) disable iff (rst)
    (ratio_ok_o && ($past(osr_sel_i) == 2'b00)) |-> (ratio_code_o >= 3'd2));

  // R5
  p_ok_high_r5: assert property (@(posedge clk) disable iff (rst)
    (ratio_ok_o && ($past(osr_sel_i) == 2'b01)) |-> (ratio_code_o <= 3'd3));

  // R6
  p_ok_float_r6: assert property (@(posedge clk) disable iff (rst)
    (ratio_ok_o && ($past(osr_sel_i) == 2'b10)) |-> (ratio_code_o <= 3'd1));

  p_ok_rsvd_r6: assert property (@(posedge clk) disable iff (rst)
    ratio_ok_o |-> ($past(osr_sel_i) != 2'b11));

  // R8: lock only on a valid code, gained without a code change, lost on any change
  p_lock_code_r8: assert property (@(posedge clk) disable iff (rst)
    locked_o |-> (ratio_code_o != 3'd7));

  p_lock_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $stable(ratio_code_o));

  p_lock_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio_code_o) |-> !locked_o);

endmodule

bind clk_ratio_mon clk_ratio_mon_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .osr_sel_i    (osr_sel_i),
  .ratio_code_o (ratio_code_o),
  .ratio_ok_o   (ratio_ok_o),
  .locked_o     (locked_o)
);

// File: tb/test_clk_ratio_mon.sv
module test_clk_ratio_mon;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bclk = 1'b0;
  logic       lrclk = 1'b0;
  logic [1:0] osr = 2'b00;
  logic [2:0] ratio_code;
  logic       ratio_ok, bclk_fast, locked;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // stimulus controls
  int per = 256;
  int bc_half = 4;
  bit stop_lr = 1'b0;
  int phase = 0;
  int bcnt = 0;

  always #4 clk = ~clk;

  clk_ratio_mon i_clk_ratio_mon (
    .clk          (clk),
    .rst          (rst),
    .bclk_i       (bclk),
    .lrclk_i      (lrclk),
    .osr_sel_i    (osr),
    .ratio_code_o (ratio_code),
    .ratio_ok_o   (ratio_ok),
    .bclk_fast_o  (bclk_fast),
    .locked_o     (locked)
  );

  function automatic int classify(input int m);
    int noms[6] = '{128, 192, 256, 384, 512, 768};
    for (int i = 0; i < 6; i++) begin
      if (m >= noms[i] - 2 && m <= noms[i] + 2) return i;
    end
    return 7;
  endfunction

  function automatic bit legal(input int code, input logic [1:0] s);
    if (code == 7) return 1'b0;
    case (s)
      2'b00:   return code >= 2 && code <= 5;
      2'b01:   return code <= 3;
      2'b10:   return code <= 1;
      default: return 1'b0;
    endcase
  endfunction

  // behavioural reference model
  int  lr_hist[$];
  int  bc_hist[$];
  int  pend_val[$];
  int  pend_age[$];
  int  mcnt;
  bit  mseen;
  int  e_code = 7;
  bit  e_ok, e_lock, e_fast;
  int  run;
  bit  acc, pchg;

  always @(posedge clk) begin
    if (rst) begin
      lr_hist = '{0, 0, 0};
      bc_hist = '{0, 0, 0};
      pend_val = {};
      pend_age = {};
      mcnt = 0; mseen = 0;
      e_code = 7; e_ok = 0; e_lock = 0; e_fast = 0;
      run = 0; acc = 0; pchg = 0;
    end else begin
      bit rise, chg, viol;
      rise = (lr_hist[1] == 1) && (lr_hist[2] == 0);
      chg  = (bc_hist[1] != bc_hist[2]);
      lr_hist.push_front(int'(lrclk)); void'(lr_hist.pop_back());
      bc_hist.push_front(int'(bclk));  void'(bc_hist.pop_back());
      // results reach the outputs two edges after the period is closed
      foreach (pend_age[k]) pend_age[k] = pend_age[k] + 1;
      if (pend_age.size() > 0 && pend_age[0] >= 2) begin
        int c;
        c = classify(pend_val[0]);
        void'(pend_val.pop_front()); void'(pend_age.pop_front());
        if (c == 7) run = 0;
        else if (c == e_code) run = (run < 3) ? run + 1 : 3;
        else run = 1;
        e_code = c;
        e_lock = (run >= 3);
      end
      e_ok = legal(e_code, osr);
      if (rise) begin
        if (mseen) begin pend_val.push_back(mcnt); pend_age.push_back(0); end
        mseen = 1; mcnt = 1;
      end else if (mcnt == 1023) begin
        pend_val.push_back(1023); pend_age.push_back(0);
        mseen = 0; mcnt = 1;
      end else begin
        mcnt = mcnt + 1;
      end
      viol = chg && pchg;
      pchg = chg;
      if (viol) e_fast = 1;
      else if (rise) e_fast = acc;
      acc = rise ? 1'b0 : (acc | viol);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, then drive the asynchronous clocks
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 model ratio_code", ratio_code, e_code);
      chk("R7 model ratio_ok", ratio_ok, e_ok);
      chk("R8 model locked", locked, e_lock);
      chk("R10 model bclk_fast", bclk_fast, e_fast);
    end
    if (stop_lr) lrclk <= 1'b0;
    else begin
      lrclk <= (phase < per / 2);
      phase = phase + 1;
      if (phase >= per) phase = 0;
    end
    if (bc_half > 0) begin
      bcnt = bcnt + 1;
      if (bcnt >= bc_half) begin bclk <= ~bclk; bcnt = 0; end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frames(input int n);
    cyc(n * per);
  endtask

  task automatic wait_code_change(input int old);
    for (int i = 0; i < 5000; i++) begin
      if (ratio_code != old) break;
      @(negedge clk);
    end
  endtask

  initial begin
    cyc(5);
    chk("R1 reset ratio_code", ratio_code, 7);
    chk("R1 reset ratio_ok", ratio_ok, 0);
    chk("R1 reset locked", locked, 0);
    chk("R1 reset bclk_fast", bclk_fast, 0);
    rst = 1'b0;
    cyc(200);
    chk("R2 first edge gives no measurement", ratio_code, 7);

    frames(6);
    chk("R3 256 code", ratio_code, 2);
    chk("R4 256 legal low", ratio_ok, 1);
    chk("R8 locked at 256", locked, 1);
    chk("R11 slow bclk", bclk_fast, 0);

    osr = 2'b10; cyc(3);
    chk("R6 256 illegal floating", ratio_ok, 0);
    osr = 2'b11; cyc(3);
    chk("R6 reserved never legal", ratio_ok, 0);
    osr = 2'b00; cyc(3);
    chk("R7 ok follows osr", ratio_ok, 1);

    per = 384;
    wait_code_change(2);
    chk("R8 lock drops on change", locked, 0);
    frames(5);
    chk("R3 384 code", ratio_code, 3);
    chk("R8 relock at 384", locked, 1);
    per = 512; frames(6);
    chk("R3 512 code", ratio_code, 4);
    chk("R4 512 legal low", ratio_ok, 1);
    per = 768; frames(6);
    chk("R3 768 code", ratio_code, 5);
    chk("R4 768 legal low", ratio_ok, 1);
    osr = 2'b01; cyc(3);
    chk("R5 768 illegal high", ratio_ok, 0);

    per = 128; frames(8);
    chk("R3 128 code", ratio_code, 0);
    chk("R5 128 legal high", ratio_ok, 1);
    per = 192; frames(8);
    chk("R3 192 code", ratio_code, 1);
    osr = 2'b10; cyc(3);
    chk("R6 192 legal floating", ratio_ok, 1);
    per = 384; frames(6);
    chk("R6 384 illegal floating", ratio_ok, 0);

    osr = 2'b01;
    per = 130; frames(8);
    chk("R3 130 accepted", ratio_code, 0);
    per = 131; frames(8);
    chk("R3 131 rejected", ratio_code, 7);
    chk("R8 no lock on code 7", locked, 0);
    per = 126; frames(8);
    chk("R3 126 accepted", ratio_code, 0);
    per = 125; frames(8);
    chk("R3 125 rejected", ratio_code, 7);

    osr = 2'b00; per = 256; frames(6);
    chk("R8 locked before stop", locked, 1);
    stop_lr = 1'b1; cyc(1100);
    chk("R9 stopped frame clock code", ratio_code, 7);
    chk("R9 stopped frame clock lock", locked, 0);
    stop_lr = 1'b0; frames(6);
    chk("R2 measurement resumes", ratio_code, 2);

    bc_half = 1; frames(1);
    chk("R10 fast bclk flagged", bclk_fast, 1);
    bc_half = 2; frames(3);
    chk("R11 two-cycle bclk not flagged", bclk_fast, 0);
    bc_half = 1; cyc(20);
    chk("R10 flag sets at once", bclk_fast, 1);
    bc_half = 0; frames(3);
    chk("R10 flag clears after clean frame", bclk_fast, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule